// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Interface

This block sits between a CPU-side access request and a set of shared external pins. It presents a 24-bit address over three pin groups: a dedicated group for the low address byte, plus two groups that also carry data. Time sharing follows an active-low enable strobe supplied from outside. While the strobe is high, the shared groups carry the upper address bytes. While it is low, they carry or receive data bytes.

A width-select input picks between a 16-bit external bus and an 8-bit external bus. On the 16-bit bus, even bytes travel on the low group and odd bytes on the high group. On the 8-bit bus, every byte travels on the low group. A word that does not fit in one bus cycle is broken into two byte cycles, low byte first, at consecutive addresses.

Reads flagged as internal take their result from the internal memory port and disregard the pins. Two fixed register addresses always use the 16-bit lane layout and are reported as internal-timed, whatever the width select says. A request is accepted while the block is idle. A one-cycle completion pulse follows the last enable-strobe rise of the access.

Top module: `mbx_bus_iface`

## Requirements
- R1: While an access is active and `en_n_i` is high (address phase), `addr_pin_o` shows address bits 7:0, `hi_pin_o` bits 15:8 and `lo_pin_o` bits 23:16, with both `hi_pin_oe_o` and `lo_pin_oe_o` high.
- R2: With the 16-bit layout in effect, the data phase (`en_n_i` low) places an odd-address byte on the high group and an even-address byte on the low group. An aligned word uses both groups, with bits 15:8 on the high group. `bhe_n_o` is low for an odd byte or a word and high for an even byte, and holds that value for the whole bus cycle.
- R3: With the 8-bit layout (`narrow_bus_i` high at acceptance, not a special address), every data byte uses the low group. The high group output enable stays low in the data phase, and `bhe_n_o` stays high.
- R4: A word request is split into two byte cycles when the 8-bit layout applies or the address is odd. The first cycle uses the request address and data bits 7:0. The second uses the address plus one and data bits 15:8.
- R5: Data-phase output enables are high only for write accesses, and only on the group carrying a byte. During reads both groups are released.
- R6: External read data is sampled from the pins during the data phase. A byte read returns its byte in `rdata_o[7:0]` with bits 15:8 zero. A word read returns the low-address byte in bits 7:0.
- R7: A read with `req_internal_i` set returns `int_rdata_i` in `rdata_o`, whatever values are on the pins.
- R8: Requests whose address bits 23:1 equal those of 0x00000A or 0x00000C use the 16-bit layout regardless of `narrow_bus_i`. `int_timed_o` is high while such an access, or any internal access, is active.
- R9: `req_ready_o` is high when idle, and a request is taken on a clock edge with `req_valid_i` high. `done_o` pulses for one cycle after the edge that sees `en_n_i` high following the last data phase. `rw_o` is low during a write access and high otherwise. Both output enables are low while idle.
- R10: After reset: `req_ready_o`=1, `done_o`=0, both output enables 0, `rw_o`=1, `bhe_n_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle, request can be taken |
| req_addr_i | input | 24 | Byte address |
| req_wdata_i | input | 16 | Write data, low byte at the request address |
| req_word_i | input | 1 | 1 = word access, 0 = byte |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_internal_i | input | 1 | Target is internal memory |
| narrow_bus_i | input | 1 | 1 = 8-bit external bus, 0 = 16-bit |
| en_n_i | input | 1 | Enable strobe, low = data phase |
| int_rdata_i | input | 16 | Read data from internal memory |
| addr_pin_o | output | 8 | Dedicated address bits 7:0 |
| hi_pin_o | output | 8 | High shared group: A15:8 or odd data |
| hi_pin_oe_o | output | 1 | High group output enable |
| hi_pin_i | input | 8 | High shared group input |
| lo_pin_o | output | 8 | Low shared group: A23:16 or even/all data |
| lo_pin_oe_o | output | 1 | Low group output enable |
| lo_pin_i | input | 8 | Low shared group input |
| rw_o | output | 1 | 1 = read, 0 = write |
| bhe_n_o | output | 1 | Odd byte lane valid, active low |
| int_timed_o | output | 1 | Active access is timed as internal |
| done_o | output | 1 | Access complete pulse |
| rdata_o | output | 16 | Read result, valid with done_o on reads |

## Verification
On every cycle, the assertions check the following:
- both groups are driven in the address phase;
- reads never drive the data pins;
- the 8-bit layout keeps the high group quiet with `bhe_n_o` high;
- a split step advances the address by exactly one;
- the completion pulse lasts one cycle;
- the pins float while idle.

The bench scenarios are needed for the rest:
- the values carried on each lane;
- the order of bytes in a split word;
- the assembled read result;
- the substitution of internal data;
- the width override at the two special addresses.

These are swept over every combination of width select, direction, size and internal flag at aligned, odd and special addresses.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

   // Lane usage for the current bus cycle
   typedef struct packed {
      logic use_hi;
      logic use_lo;
      logic bhe_n;
   } lane_ctl_t;

endpackage

// File: rtl/mbx_lane_steer.sv
module mbx_lane_steer
   import mbx_pkg::*;
#(
   parameter int LANE_W = 8
) (
   input  logic                  wide_i,
   input  logic                  a0_i,
   input  logic                  whole_i,
   input  logic                  part_i,
   input  logic [2*LANE_W-1:0]   wdata_i,
   output lane_ctl_t             ctl_o,
   output logic [LANE_W-1:0]     hi_data_o,
   output logic [LANE_W-1:0]     lo_data_o
);

   logic [LANE_W-1:0] byte_v;

   // Second half of a split word carries the upper data byte
   assign byte_v = part_i ? wdata_i[2*LANE_W-1:LANE_W] : wdata_i[LANE_W-1:0];

   always_comb begin
      ctl_o     = '{use_hi: 1'b0, use_lo: 1'b0, bhe_n: 1'b1};
      hi_data_o = '0;
      lo_data_o = '0;
      if (wide_i && whole_i) begin
         ctl_o     = '{use_hi: 1'b1, use_lo: 1'b1, bhe_n: 1'b0};
         hi_data_o = wdata_i[2*LANE_W-1:LANE_W];
         lo_data_o = wdata_i[LANE_W-1:0];
      end else if (wide_i && a0_i) begin
         ctl_o     = '{use_hi: 1'b1, use_lo: 1'b0, bhe_n: 1'b0};
         hi_data_o = byte_v;
      end else begin
         ctl_o     = '{use_hi: 1'b0, use_lo: 1'b1, bhe_n: 1'b1};
         lo_data_o = byte_v;
      end
   end

endmodule

// File: rtl/mbx_sequencer.sv
module mbx_sequencer #(
   parameter int ADDR_W = 24,
   parameter int DATA_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid_i,
   input  logic [ADDR_W-1:0]  req_addr_i,
   input  logic [DATA_W-1:0]  req_wdata_i,
   input  logic               req_word_i,
   input  logic               req_write_i,
   input  logic               req_internal_i,
   input  logic               req_wide_i,
   input  logic               req_special_i,
   input  logic               en_n_i,
   output logic               active_o,
   output logic               part_o,
   output logic [ADDR_W-1:0]  addr_o,
   output logic [DATA_W-1:0]  wdata_o,
   output logic               write_o,
   output logic               internal_o,
   output logic               wide_o,
   output logic               whole_o,
   output logic               special_o,
   output logic               capture_o,
   output logic               finish_o,
   output logic               done_o
);

   localparam logic [ADDR_W-1:0] ADDR_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

   logic active_q, part_q, seen_low_q, done_q;
   logic split_q, word_q, write_q, int_q, wide_q, special_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic last_part;
   logic req_split;

   assign req_split = req_word_i && (!req_wide_i || req_addr_i[0]);
   assign last_part = !(split_q && !part_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q   <= 1'b0;
         part_q     <= 1'b0;
         seen_low_q <= 1'b0;
         done_q     <= 1'b0;
         split_q    <= 1'b0;
         word_q     <= 1'b0;
         write_q    <= 1'b0;
         int_q      <= 1'b0;
         wide_q     <= 1'b0;
         special_q  <= 1'b0;
         addr_q     <= '0;
         wdata_q    <= '0;
      end else begin
         done_q <= 1'b0;
         if (!active_q) begin
            if (req_valid_i) begin
               active_q   <= 1'b1;
               part_q     <= 1'b0;
               seen_low_q <= 1'b0;
               split_q    <= req_split;
               word_q     <= req_word_i;
               write_q    <= req_write_i;
               int_q      <= req_internal_i;
               wide_q     <= req_wide_i;
               special_q  <= req_special_i;
               addr_q     <= req_addr_i;
               wdata_q    <= req_wdata_i;
            end
         end else if (!en_n_i) begin
            seen_low_q <= 1'b1;
         end else if (seen_low_q) begin
            seen_low_q <= 1'b0;
            if (!last_part) begin
               part_q <= 1'b1;
               addr_q <= addr_q + ADDR_ONE;
            end else begin
               active_q <= 1'b0;
               done_q   <= 1'b1;
            end
         end
      end
   end

   assign active_o   = active_q;
   assign part_o     = part_q;
   assign addr_o     = addr_q;
   assign wdata_o    = wdata_q;
   assign write_o    = write_q;
   assign internal_o = int_q;
   assign wide_o     = wide_q;
   assign whole_o    = word_q && !split_q;
   assign special_o  = special_q;
   assign capture_o  = active_q && !en_n_i;
   assign finish_o   = active_q && en_n_i && seen_low_q && last_part;
   assign done_o     = done_q;

   AST_SPLIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(part_q) |-> (addr_q == $past(addr_q) + ADDR_ONE)); // R4

endmodule

// File: rtl/mbx_read_capture.sv
module mbx_read_capture #(
   parameter int LANE_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 capture_i,
   input  logic                 finish_i,
   input  logic                 whole_i,
   input  logic                 sel_hi_i,
   input  logic                 part_i,
   input  logic                 internal_i,
   input  logic [LANE_W-1:0]    hi_pin_i,
   input  logic [LANE_W-1:0]    lo_pin_i,
   input  logic [2*LANE_W-1:0]  int_rdata_i,
   output logic [2*LANE_W-1:0]  rdata_o
);

   logic [2*LANE_W-1:0] asm_q;
   logic [2*LANE_W-1:0] rdata_q;
   logic [LANE_W-1:0]   byte_in;

   assign byte_in = sel_hi_i ? hi_pin_i : lo_pin_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         asm_q   <= '0;
         rdata_q <= '0;
      end else begin
         if (capture_i) begin
            if (whole_i)
               asm_q <= {hi_pin_i, lo_pin_i};
            else if (!part_i)
               asm_q <= {{LANE_W{1'b0}}, byte_in};
            else
               asm_q[2*LANE_W-1:LANE_W] <= byte_in;
         end
         if (finish_i)
            rdata_q <= internal_i ? int_rdata_i : asm_q;
      end
   end

   assign rdata_o = rdata_q;

endmodule

// File: rtl/mbx_bus_iface.sv
module mbx_bus_iface
   import mbx_pkg::*;
#(
   parameter int              ADDR_W     = 24,
   parameter int              DATA_W     = 16,
   parameter bit              SPECIAL_EN = 1'b1,
   parameter logic [23:0]     SPEC_A     = 24'h00000A,
   parameter logic [23:0]     SPEC_B     = 24'h00000C,
   localparam int             LANE_W     = DATA_W / 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid_i,
   output logic               req_ready_o,
   input  logic [ADDR_W-1:0]  req_addr_i,
   input  logic [DATA_W-1:0]  req_wdata_i,
   input  logic               req_word_i,
   input  logic               req_write_i,
   input  logic               req_internal_i,
   input  logic               narrow_bus_i,
   input  logic               en_n_i,
   input  logic [DATA_W-1:0]  int_rdata_i,
   output logic [LANE_W-1:0]  addr_pin_o,
   output logic [LANE_W-1:0]  hi_pin_o,
   output logic               hi_pin_oe_o,
   input  logic [LANE_W-1:0]  hi_pin_i,
   output logic [LANE_W-1:0]  lo_pin_o,
   output logic               lo_pin_oe_o,
   input  logic [LANE_W-1:0]  lo_pin_i,
   output logic               rw_o,
   output logic               bhe_n_o,
   output logic               int_timed_o,
   output logic               done_o,
   output logic [DATA_W-1:0]  rdata_o
);

   // Elaboration-time parameter checks
   if (DATA_W % 2 != 0) begin : g_bad_data
      $error("DATA_W must be even");
   end
   if (ADDR_W != 3 * LANE_W) begin : g_bad_addr
      $error("ADDR_W must equal three lane widths");
   end
   if (ADDR_W != 24) begin : g_bad_spec
      $error("special addresses are defined for a 24-bit address");
   end

   logic req_special, req_wide;

   if (SPECIAL_EN) begin : g_spec
      assign req_special = (req_addr_i[ADDR_W-1:1] == SPEC_A[ADDR_W-1:1]) ||
                           (req_addr_i[ADDR_W-1:1] == SPEC_B[ADDR_W-1:1]);
   end else begin : g_nospec
      assign req_special = 1'b0;
   end

   assign req_wide = !narrow_bus_i || req_special;

   logic              active, part, write_q, int_q, wide_q, whole_q, special_q;
   logic              capture, finish;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;

   mbx_sequencer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
      .clk            (clk),
      .rst_n          (rst_n),
      .req_valid_i    (req_valid_i),
      .req_addr_i     (req_addr_i),
      .req_wdata_i    (req_wdata_i),
      .req_word_i     (req_word_i),
      .req_write_i    (req_write_i),
      .req_internal_i (req_internal_i),
      .req_wide_i     (req_wide),
      .req_special_i  (req_special),
      .en_n_i         (en_n_i),
      .active_o       (active),
      .part_o         (part),
      .addr_o         (addr_q),
      .wdata_o        (wdata_q),
      .write_o        (write_q),
      .internal_o     (int_q),
      .wide_o         (wide_q),
      .whole_o        (whole_q),
      .special_o      (special_q),
      .capture_o      (capture),
      .finish_o       (finish),
      .done_o         (done_o)
   );

   lane_ctl_t         ctl;
   logic [LANE_W-1:0] hi_data, lo_data;

   mbx_lane_steer #(.LANE_W(LANE_W)) u_steer (
      .wide_i    (wide_q),
      .a0_i      (addr_q[0]),
      .whole_i   (whole_q),
      .part_i    (part),
      .wdata_i   (wdata_q),
      .ctl_o     (ctl),
      .hi_data_o (hi_data),
      .lo_data_o (lo_data)
   );

   mbx_read_capture #(.LANE_W(LANE_W)) u_rd (
      .clk         (clk),
      .rst_n       (rst_n),
      .capture_i   (capture),
      .finish_i    (finish),
      .whole_i     (whole_q),
      .sel_hi_i    (wide_q && addr_q[0]),
      .part_i      (part),
      .internal_i  (int_q),
      .hi_pin_i    (hi_pin_i),
      .lo_pin_i    (lo_pin_i),
      .int_rdata_i (int_rdata_i),
      .rdata_o     (rdata_o)
   );

   logic addr_phase, data_wr, hi_drv, lo_drv;

   assign addr_phase = active && en_n_i;
   assign data_wr    = active && !en_n_i && write_q;
   assign hi_drv     = data_wr && ctl.use_hi;
   assign lo_drv     = data_wr && ctl.use_lo;

   assign addr_pin_o  = addr_q[LANE_W-1:0];
   assign hi_pin_o    = addr_phase ? addr_q[2*LANE_W-1:LANE_W] : (hi_drv ? hi_data : '0);
   assign lo_pin_o    = addr_phase ? addr_q[3*LANE_W-1:2*LANE_W] : (lo_drv ? lo_data : '0);
   assign hi_pin_oe_o = addr_phase || hi_drv;
   assign lo_pin_oe_o = addr_phase || lo_drv;
   assign rw_o        = !(active && write_q);
   assign bhe_n_o     = active ? ctl.bhe_n : 1'b1;
   assign int_timed_o = active && (int_q || special_q);
   assign req_ready_o = !active;

   AST_ADDR_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (active && en_n_i) |-> (hi_pin_oe_o && lo_pin_oe_o)); // R1
   AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !en_n_i && !write_q) |-> (!hi_pin_oe_o && !lo_pin_oe_o)); // R5
   AST_NARROW_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !en_n_i && !wide_q) |-> (!hi_pin_oe_o && bhe_n_o)); // R3
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R9
   AST_IDLE_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready_o |-> (!hi_pin_oe_o && !lo_pin_oe_o && rw_o)); // R9

endmodule

// File: tb/tb_mbx_bus_iface.sv
`timescale 1ns/1ps
module tb_mbx_bus_iface;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [23:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        req_word = 1'b0;
   logic        req_write = 1'b0;
   logic        req_internal = 1'b0;
   logic        narrow_bus = 1'b0;
   logic        en_n = 1'b1;
   logic [15:0] int_rdata = 16'hBEEF;
   logic [7:0]  addr_pin, hi_pin, lo_pin;
   logic        hi_oe, lo_oe;
   logic [7:0]  hi_in = '0, lo_in = '0;
   logic        rw, bhe_n, int_timed, done;
   logic [15:0] rdata;

   int vectors = 0;
   int miscompares = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   mbx_bus_iface dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid_i(req_valid), .req_ready_o(req_ready),
      .req_addr_i(req_addr), .req_wdata_i(req_wdata),
      .req_word_i(req_word), .req_write_i(req_write),
      .req_internal_i(req_internal), .narrow_bus_i(narrow_bus),
      .en_n_i(en_n), .int_rdata_i(int_rdata),
      .addr_pin_o(addr_pin), .hi_pin_o(hi_pin), .hi_pin_oe_o(hi_oe),
      .hi_pin_i(hi_in), .lo_pin_o(lo_pin), .lo_pin_oe_o(lo_oe),
      .lo_pin_i(lo_in), .rw_o(rw), .bhe_n_o(bhe_n),
      .int_timed_o(int_timed), .done_o(done), .rdata_o(rdata)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic run_access(input logic [23:0] a, input bit nb, input bit wr,
                             input bit wd, input bit inn, input logic [15:0] wv);
      bit sp, wide, split, whole;
      int parts;
      logic [23:0] pa;
      logic [7:0]  bv, bexp, ehd, eld;
      bit          ehoe, eloe, ebhe;
      logic [15:0] exp_rd;
      string       tag;
      sp    = (a[23:1] == 23'h5) || (a[23:1] == 23'h6);
      wide  = !nb || sp;
      split = wd && (!wide || a[0]);
      whole = wd && !split;
      parts = split ? 2 : 1;
      exp_rd = '0;

      @(negedge clk);
      req_addr = a; req_wdata = wv; req_word = wd; req_write = wr;
      req_internal = inn; narrow_bus = nb; req_valid = 1'b1; en_n = 1'b1;
      @(negedge clk);
      // Scramble request inputs: the access must use latched values
      req_valid = 1'b0; req_addr = ~a; req_wdata = ~wv; narrow_bus = !nb;
      for (int p = 0; p < parts; p++) begin
         pa = a + 24'(p);
         tag = (p == 1) ? "R4" : "R1";
         chk({addr_pin, hi_pin, lo_pin} == {pa[7:0], pa[15:8], pa[23:16]}, tag,
             {8'h0, addr_pin, hi_pin, lo_pin}, {8'h0, pa[7:0], pa[15:8], pa[23:16]});
         chk(hi_oe && lo_oe, "R1", {hi_oe, lo_oe}, 2'b11);
         chk(rw == !wr && !req_ready, "R9", {rw, req_ready}, {!wr, 1'b0});
         chk(int_timed == (inn || sp), "R8", int_timed, inn || sp);

         hi_in = p ? 8'h6D : 8'h5A;
         lo_in = p ? 8'h19 : 8'hC3;
         en_n = 1'b0;
         #1;
         bv = p ? wv[15:8] : wv[7:0];
         ehd = '0; eld = '0;
         if (wide && whole) begin
            ehoe = 1; eloe = 1; ebhe = 0; ehd = wv[15:8]; eld = wv[7:0];
         end else if (wide && pa[0]) begin
            ehoe = 1; eloe = 0; ebhe = 0; ehd = bv;
         end else begin
            ehoe = 0; eloe = 1; ebhe = 1; eld = bv;
         end
         if (!wr) begin ehoe = 0; eloe = 0; end
         tag = !wr ? "R5" : (split ? "R4" : (sp && nb ? "R8" : (wide ? "R2" : "R3")));
         chk({hi_oe, lo_oe, bhe_n} == {ehoe, eloe, ebhe}, tag,
             {hi_oe, lo_oe, bhe_n}, {ehoe, eloe, ebhe});
         if (ehoe) chk(hi_pin == ehd, tag, hi_pin, ehd);
         if (eloe) chk(lo_pin == eld, tag, lo_pin, eld);

         if (whole) exp_rd = {hi_in, lo_in};
         else begin
            bexp = (wide && pa[0]) ? hi_in : lo_in;
            if (p == 0) exp_rd[7:0] = bexp;
            else        exp_rd[15:8] = bexp;
         end
         @(negedge clk);
         en_n = 1'b1;
         @(negedge clk);
      end
      chk(done && req_ready, "R9", {done, req_ready}, 2'b11);
      if (!wr) begin
         if (inn) chk(rdata == int_rdata, "R7", rdata, int_rdata);
         else     chk(rdata == exp_rd, "R6", rdata, exp_rd);
      end
      @(negedge clk);
      chk(!done && !hi_oe && !lo_oe && rw, "R9", {done, hi_oe, lo_oe, rw}, 4'b0001);
   endtask

   initial begin
      logic [23:0] alist [5];
      alist = '{24'h123456, 24'h3456A7, 24'h00000A, 24'h00000D, 24'h00000C};
      repeat (3) @(negedge clk);
      chk(req_ready && !done && !hi_oe && !lo_oe && rw && bhe_n, "R10",
          {req_ready, done, hi_oe, lo_oe, rw, bhe_n}, 6'b100011);
      rst_n = 1'b1;
      @(negedge clk);
      for (int ai = 0; ai < 5; ai++)
         for (int nb = 0; nb < 2; nb++)
            for (int wr = 0; wr < 2; wr++)
               for (int wd = 0; wd < 2; wd++)
                  for (int inn = 0; inn < 2; inn++)
                     run_access(alist[ai], nb[0], wr[0], wd[0], inn[0],
                                16'h9C3E ^ {8'(ai), 8'(ai * 3)});
      if (!finished) begin
         finished = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      #(8 * 200000);
      if (!finished) begin
         finished = 1;
         vectors++;
         miscompares++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

endmodule